// File: doc/BRIEF.md
# Sixteen-Function 8-bit ALU

A combinational arithmetic/logic unit for a simple single-bus datapath. Two 8-bit operands and a 4-bit function code select one of sixteen functions: packed-BCD add and subtract, binary add and subtract, bitwise logic, increment, operand pass-through, two clear variants (one of which loads the flags from operand B), either half of an 8x8 product, and unsigned quotient and remainder. Every function yields an 8-bit result together with carry and zero flags. The add and subtract functions take a carry input, so multi-byte operands can be processed one byte at a time.

A small holding register sits beside the combinational path. When `load_i` is high at a rising clock edge it captures the result and both flags. The captured copy can then be placed on a shared bus in a later cycle while the operands change.

Top module: `alu16`

## Requirements
- R1: Code 0 adds A, B and `carry_i` as two-digit packed BCD. `carry_o` is 1 when the decimal sum exceeds 99, and the result holds the low two decimal digits.
- R2: Code 1 computes A − B − `carry_i` in packed BCD. If the difference is negative, the result is 100 plus the difference and `carry_o` is 1 (borrow); otherwise `carry_o` is 0.
- R3: Codes 2, 3 and 4 return A AND B, A OR B and A XOR B respectively, with `carry_o` 0.
- R4: Code 5 returns A+1 modulo 256. `carry_o` is 1 only when A is 0xFF, and `carry_i` has no effect.
- R5: Code 6 returns 0x00, with `carry_o` equal to B bit 0 and `zero_o` equal to B bit 1.
- R6: Code 7 returns 0x00 with `carry_o` 0 and `zero_o` 1.
- R7: Code 8 returns A+B+`carry_i` with `carry_o` as the carry out of bit 7. Code 9 returns A−B−`carry_i` modulo 256 with `carry_o` 1 on borrow.
- R8: Codes 10 and 11 return A and B unchanged respectively, with `carry_o` 0.
- R9: Codes 12 and 13 return the high and low byte of the unsigned product A*B respectively, with `carry_o` 0.
- R10: Codes 14 and 15 return the unsigned quotient A/B and remainder A%B respectively, with `carry_o` 0, when B is not zero.
- R11: Codes 14 and 15 with B equal to 0x00 return 0xFF with `carry_o` 1.
- R12: For every code except 6, `zero_o` is 1 exactly when the result is 0x00.
- R13: On a rising `clk_i` edge with `load_i` high, the held outputs take the current result and flags. With `load_i` low they keep their value. A low `rst_ni` clears them to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the holding register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Function code |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| carry_i | input | 1 | Carry/borrow in for add and subtract codes |
| load_i | input | 1 | Capture result into holding register |
| res_o | output | 8 | Combinational result |
| carry_o | output | 1 | Combinational carry/borrow/error flag |
| zero_o | output | 1 | Combinational zero flag |
| held_res_o | output | 8 | Held result |
| held_carry_o | output | 1 | Held carry flag |
| held_zero_o | output | 1 | Held zero flag |

## Verification
The assertions assume that operands are stable around each rising clock edge. They also assume that `load_i` and the other inputs are known once reset is released. They check flag relations only; they do not check decimal validity. The BCD codes give meaningful results only for operands whose nibbles are 0 to 9, so every stimulus vector for codes 0 and 1 uses valid packed-BCD operands. The bench changes inputs only just after falling edges, so each value is settled well before the edge at which the checker and the holding register sample it.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [3:0] {
    OP_DADD  = 4'd0,
    OP_DSUB  = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_INC   = 4'd5,
    OP_FLAGB = 4'd6,
    OP_CLR   = 4'd7,
    OP_ADD   = 4'd8,
    OP_SUB   = 4'd9,
    OP_PASSA = 4'd10,
    OP_PASSB = 4'd11,
    OP_MULH  = 4'd12,
    OP_MULL  = 4'd13,
    OP_DIV   = 4'd14,
    OP_MOD   = 4'd15
  } op_e;
endpackage

// File: rtl/alu16_bcd.sv
module alu16_bcd #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int unsigned ND = W / 4;

  logic [ND:0] c;
  assign c[0] = cin_i;

  for (genvar g = 0; g < ND; g++) begin : g_digit
    logic [3:0] da, db;
    logic [4:0] s, d;
    logic       gt9, neg;
    assign da  = a_i[4*g +: 4];
    assign db  = b_i[4*g +: 4];
    assign s   = {1'b0, da} + {1'b0, db} + {4'd0, c[g]};
    assign d   = {1'b0, da} - {1'b0, db} - {4'd0, c[g]};
    assign gt9 = (s > 5'd9);
    assign neg = d[4];
    always_comb begin
      if (sub_i) begin
        res_o[4*g +: 4] = neg ? d[3:0] + 4'd10 : d[3:0];
        c[g+1]          = neg;
      end else begin
        res_o[4*g +: 4] = gt9 ? s[3:0] + 4'd6 : s[3:0];
        c[g+1]          = gt9;
      end
    end
  end

  assign cout_o = c[ND];
endmodule

// File: rtl/alu16_arith.sv
module alu16_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           cin_i,
  output logic [W:0]     add_o,
  output logic [W:0]     sub_o,
  output logic [W:0]     inc_o,
  output logic [2*W-1:0] prod_o
);
  logic [W:0] ax, bx, cx;
  assign ax = {1'b0, a_i};
  assign bx = {1'b0, b_i};
  assign cx = {{W{1'b0}}, cin_i};

  assign add_o  = ax + bx + cx;
  // bit W of the difference is the borrow
  assign sub_o  = ax - bx - cx;
  assign inc_o  = ax + {{W{1'b0}}, 1'b1};
  assign prod_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
endmodule

// File: rtl/alu16_divider.sv
module alu16_divider #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         dz_o
);
  logic [W:0]   r;
  logic [W-1:0] q;

  // restoring division, one compare/subtract stage per dividend bit
  always_comb begin
    r = '0;
    q = '0;
    for (int i = W - 1; i >= 0; i--) begin
      r = {r[W-1:0], a_i[i]};
      if (r >= {1'b0, b_i}) begin
        r    = r - {1'b0, b_i};
        q[i] = 1'b1;
      end
    end
  end

  assign dz_o  = (b_i == '0);
  assign quo_o = dz_o ? '1 : q;
  assign rem_o = dz_o ? '1 : r[W-1:0];
endmodule

// File: rtl/alu16.sv
module alu16 #(
  parameter int unsigned W = alu16_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         load_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic [W-1:0] held_res_o,
  output logic         held_carry_o,
  output logic         held_zero_o
);
  import alu16_pkg::*;

  op_e op;
  assign op = op_e'(op_i);

  logic [W-1:0]   bcd_res, quo, rem;
  logic           bcd_c, dz;
  logic [W:0]     add_r, sub_r, inc_r;
  logic [2*W-1:0] prod;

  alu16_bcd #(.W(W)) u_bcd (
    .a_i(a_i), .b_i(b_i), .cin_i(carry_i), .sub_i(op == OP_DSUB),
    .res_o(bcd_res), .cout_o(bcd_c)
  );

  alu16_arith #(.W(W)) u_arith (
    .a_i(a_i), .b_i(b_i), .cin_i(carry_i),
    .add_o(add_r), .sub_o(sub_r), .inc_o(inc_r), .prod_o(prod)
  );

  alu16_divider #(.W(W)) u_div (
    .a_i(a_i), .b_i(b_i), .quo_o(quo), .rem_o(rem), .dz_o(dz)
  );

  logic [W-1:0] res_d;
  logic         c_d;

  always_comb begin
    res_d = '0;
    c_d   = 1'b0;
    unique case (op)
      OP_DADD, OP_DSUB: begin res_d = bcd_res;      c_d = bcd_c;    end
      OP_AND:           res_d = a_i & b_i;
      OP_OR:            res_d = a_i | b_i;
      OP_XOR:           res_d = a_i ^ b_i;
      OP_INC:           begin res_d = inc_r[W-1:0]; c_d = inc_r[W]; end
      OP_FLAGB:         c_d   = b_i[0];
      OP_CLR:           res_d = '0;
      OP_ADD:           begin res_d = add_r[W-1:0]; c_d = add_r[W]; end
      OP_SUB:           begin res_d = sub_r[W-1:0]; c_d = sub_r[W]; end
      OP_PASSA:         res_d = a_i;
      OP_PASSB:         res_d = b_i;
      OP_MULH:          res_d = prod[2*W-1:W];
      OP_MULL:          res_d = prod[W-1:0];
      OP_DIV:           begin res_d = quo;          c_d = dz;       end
      OP_MOD:           begin res_d = rem;          c_d = dz;       end
      default:          res_d = '0;
    endcase
  end

  assign res_o   = res_d;
  assign carry_o = c_d;
  assign zero_o  = (op == OP_FLAGB) ? b_i[1] : (res_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_res_o   <= '0;
      held_carry_o <= 1'b0;
      held_zero_o  <= 1'b0;
    end else if (load_i) begin
      held_res_o   <= res_o;
      held_carry_o <= carry_o;
      held_zero_o  <= zero_o;
    end
  end
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         load_i,
  input logic [W-1:0] res_o,
  input logic         carry_o,
  input logic         zero_o,
  input logic [W-1:0] held_res_o,
  input logic         held_carry_o,
  input logic         held_zero_o
);
  // R3
  logic_no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {4'd2, 4'd3, 4'd4}) |-> !carry_o);

  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7) |-> (res_o == '0 && zero_o && !carry_o));

  // R8
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd10) |-> (res_o == a_i));

  // R11
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {4'd14, 4'd15} && b_i == '0) |-> (res_o == '1 && carry_o));

  // R12
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 4'd6) |-> (zero_o == (res_o == '0)));

  // R13
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (held_res_o == $past(res_o) && held_carry_o == $past(carry_o)
                && held_zero_o == $past(zero_o)));

  // R13
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(held_res_o) && $stable(held_carry_o) && $stable(held_zero_o)));
endmodule

bind alu16 alu16_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .load_i(load_i), .res_o(res_o), .carry_o(carry_o), .zero_o(zero_o),
  .held_res_o(held_res_o), .held_carry_o(held_carry_o), .held_zero_o(held_zero_o)
);

// File: tb/alu16_test.sv
`timescale 1ns/1ps
module alu16_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic       carry_i = 1'b0, load_i = 1'b0;
  logic [7:0] res_o, held_res_o;
  logic       carry_o, zero_o, held_carry_o, held_zero_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  alu16 uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .carry_i(carry_i), .load_i(load_i), .res_o(res_o), .carry_o(carry_o),
    .zero_o(zero_o), .held_res_o(held_res_o), .held_carry_o(held_carry_o),
    .held_zero_o(held_zero_o)
  );

  // {op, a, b, cin, res, carry, zero}
  localparam int NV = 36;
  localparam logic [30:0] VEC [NV] = '{
    {4'd0,  8'h45, 8'h38, 1'b0, 8'h83, 1'b0, 1'b0},
    {4'd0,  8'h99, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1},
    {4'd0,  8'h58, 8'h47, 1'b1, 8'h06, 1'b1, 1'b0},
    {4'd1,  8'h52, 8'h17, 1'b0, 8'h35, 1'b0, 1'b0},
    {4'd1,  8'h17, 8'h52, 1'b0, 8'h65, 1'b1, 1'b0},
    {4'd1,  8'h40, 8'h39, 1'b1, 8'h00, 1'b0, 1'b1},
    {4'd2,  8'hF0, 8'h3C, 1'b1, 8'h30, 1'b0, 1'b0},
    {4'd3,  8'hF0, 8'h0C, 1'b0, 8'hFC, 1'b0, 1'b0},
    {4'd4,  8'hAA, 8'hAA, 1'b1, 8'h00, 1'b0, 1'b1},
    {4'd5,  8'h7F, 8'h00, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd5,  8'hFF, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1},
    {4'd5,  8'h10, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0},
    {4'd6,  8'h55, 8'h02, 1'b0, 8'h00, 1'b0, 1'b1},
    {4'd6,  8'h55, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0},
    {4'd6,  8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd7,  8'h55, 8'hFF, 1'b1, 8'h00, 1'b0, 1'b1},
    {4'd8,  8'hC8, 8'h64, 1'b0, 8'h2C, 1'b1, 1'b0},
    {4'd8,  8'h01, 8'hFE, 1'b1, 8'h00, 1'b1, 1'b1},
    {4'd8,  8'h12, 8'h34, 1'b0, 8'h46, 1'b0, 1'b0},
    {4'd9,  8'h50, 8'h20, 1'b0, 8'h30, 1'b0, 1'b0},
    {4'd9,  8'h20, 8'h50, 1'b0, 8'hD0, 1'b1, 1'b0},
    {4'd9,  8'h05, 8'h04, 1'b1, 8'h00, 1'b0, 1'b1},
    {4'd10, 8'h9C, 8'h11, 1'b1, 8'h9C, 1'b0, 1'b0},
    {4'd11, 8'h9C, 8'h11, 1'b0, 8'h11, 1'b0, 1'b0},
    {4'd11, 8'h9C, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1},
    {4'd12, 8'hFF, 8'hFF, 1'b0, 8'hFE, 1'b0, 1'b0},
    {4'd13, 8'hFF, 8'hFF, 1'b0, 8'h01, 1'b0, 1'b0},
    {4'd13, 8'h10, 8'h10, 1'b0, 8'h00, 1'b0, 1'b1},
    {4'd14, 8'hC8, 8'h07, 1'b0, 8'h1C, 1'b0, 1'b0},
    {4'd15, 8'hC8, 8'h07, 1'b0, 8'h04, 1'b0, 1'b0},
    {4'd14, 8'h05, 8'h09, 1'b0, 8'h00, 1'b0, 1'b1},
    {4'd15, 8'h05, 8'h09, 1'b0, 8'h05, 1'b0, 1'b0},
    {4'd14, 8'hFF, 8'h01, 1'b0, 8'hFF, 1'b0, 1'b0},
    {4'd14, 8'h37, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0},
    {4'd15, 8'h37, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0},
    {4'd15, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b0}
  };

  function automatic string tag(input logic [3:0] op, input logic [7:0] b);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10, 4'd11: return "R8";
      4'd12, 4'd13: return "R9";
      default: return (b == 8'h00) ? "R11" : "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R13: reset state of holding register
    #1;
    check("R13", "held_res reset", {24'd0, held_res_o}, 32'd0);
    check("R13", "held_flags reset", {30'd0, held_carry_o, held_zero_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      op_i    = VEC[i][30:27];
      a_i     = VEC[i][26:19];
      b_i     = VEC[i][18:11];
      carry_i = VEC[i][10];
      #1;
      check(tag(op_i, b_i), $sformatf("res op%0d", op_i), {24'd0, res_o}, {24'd0, VEC[i][9:2]});
      check(tag(op_i, b_i), $sformatf("carry op%0d", op_i), {31'd0, carry_o}, {31'd0, VEC[i][1]});
      check((op_i == 4'd6) ? "R5" : "R12", $sformatf("zero op%0d", op_i),
            {31'd0, zero_o}, {31'd0, VEC[i][0]});
    end

    // R13: capture on load
    @(negedge clk_i);
    op_i = 4'd8; a_i = 8'hFF; b_i = 8'h01; carry_i = 1'b0; load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    check("R13", "held_res load", {24'd0, held_res_o}, 32'h00);
    check("R13", "held_flags load", {30'd0, held_carry_o, held_zero_o}, 32'd3);

    // R13: hold while operands change and load low
    op_i = 4'd10; a_i = 8'h5A;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R13", "res live", {24'd0, res_o}, 32'h5A);
    check("R13", "held_res kept", {24'd0, held_res_o}, 32'h00);
    check("R13", "held_flags kept", {30'd0, held_carry_o, held_zero_o}, 32'd3);

    // R13: second load then async reset
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    check("R13", "held_res reload", {24'd0, held_res_o}, 32'h5A);
    #1;
    rst_ni = 1'b0;
    #1;
    check("R13", "held_res async clear", {24'd0, held_res_o}, 32'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    finish_run();
  end
endmodule